// File: doc/BRIEF.md
# Four-Function Integer ALU with Status Flags

This block is a purely combinational integer arithmetic logic unit. It takes two operands of a parameterised width (32 bits by default) and a 2-bit operation code. It returns either the bitwise AND, the bitwise OR, the sum or the difference of the operands. Every result comes with four status bits: zero, negative, carry and signed overflow.

The logic pair and the arithmetic pair always compute in parallel. The low bit of the operation code chooses inside each pair. The high bit then picks the pair that drives the result. A single adder serves both addition and subtraction: the second operand passes through an XOR stage controlled by the low code bit, and that same bit is the adder's carry-in. This gives A + ~B + 1 for subtraction. A parameter chooses the adder between an explicit ripple chain and a behavioural sum. Nothing is registered, so the block can sit directly in an execute stage.

Top module: `alu4f_top`

## Requirements
- R1: With `op_sel` = 2'b00 the result is the bitwise AND of `opnd_a` and `opnd_b`.
- R2: With `op_sel` = 2'b01 the result is the bitwise OR of `opnd_a` and `opnd_b`.
- R3: With `op_sel` = 2'b10 the result is `opnd_a + opnd_b` modulo 2^WIDTH.
- R4: With `op_sel` = 2'b11 the result is `opnd_a - opnd_b` modulo 2^WIDTH.
- R5: `flag_carry` is the carry out of the top adder stage. For addition it is 1 exactly when the unsigned sum is 2^WIDTH or more. For subtraction it is 1 exactly when `opnd_a` >= `opnd_b` as unsigned values, meaning no borrow occurred.
- R6: `flag_ovf` is 1 exactly when the two adder inputs have equal sign bits and the adder sum's sign bit differs from them. The second input is `opnd_b` after the conditional inversion. Equivalently, the signed sum (for addition) or the signed difference (for subtraction) does not fit in WIDTH bits.
- R7: `flag_neg` equals the most significant bit of `result` for every operation.
- R8: `flag_zero` is 1 exactly when every bit of `result` is 0, for logic and arithmetic operations alike.
- R9: For AND (2'b00), `flag_carry` and `flag_ovf` take the values the addition of the same operands would give. For OR (2'b01), they take the values the subtraction would give.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand; inverted internally for subtraction |
| op_sel | input | 2 | Operation code: 00 AND, 01 OR, 10 add, 11 subtract |
| result | output | WIDTH | Selected result |
| flag_zero | output | 1 | Result is all zeros |
| flag_neg | output | 1 | Result most significant bit |
| flag_carry | output | 1 | Carry out of the adder's top stage |
| flag_ovf | output | 1 | Signed overflow of the adder |

## Verification
The bench targets the signed edges 0x7FFFFFFF+1 and 0x80000000-1. There, a design that takes the overflow sign from the uninverted B operand, or that compares the wrong sign bits, misses the overflow or reports one that did not happen. The cases 0xFFFFFFFF+1 and A-A produce a zero result together with a carry. They expose a carry tapped from the wrong stage, a missing carry-in on subtraction (the result would be off by one), and a zero flag taken from a pair that was not selected. Subtraction operands are tested on both sides of the unsigned comparison, to catch a carry inverted into a borrow. Random vectors for each code, plus checks of the flags during logic operations, catch swapped pair selection and adder flags that do not follow the low code bit.

// File: rtl/alu4f_pkg.sv
package alu4f_pkg;
   typedef enum logic [1:0] {
      OP_AND = 2'b00,
      OP_OR  = 2'b01,
      OP_ADD = 2'b10,
      OP_SUB = 2'b11
   } alu_op_e;

   localparam int SEL_INNER = 0;  // picks within a pair
   localparam int SEL_PAIR  = 1;  // picks logic (0) or arithmetic (1)
endpackage

// File: rtl/alu4f_logic.sv
module alu4f_logic #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] lhs,
   input  logic [WIDTH-1:0] rhs,
   input  logic             pick_or,
   output logic [WIDTH-1:0] bits_out
);
   logic [WIDTH-1:0] and_v;
   logic [WIDTH-1:0] or_v;

   assign and_v    = lhs & rhs;
   assign or_v     = lhs | rhs;
   assign bits_out = pick_or ? or_v : and_v;

   always_comb begin
      // AND never sets a bit absent from either operand (R1)
      p_and_subset_r1: assert (pick_or || (bits_out & ~(lhs & rhs)) == '0)
         else $error("p_and_subset_r1");
      // OR keeps every bit set in either operand (R2)
      p_or_cover_r2: assert (!pick_or || ((lhs | rhs) & ~bits_out) == '0)
         else $error("p_or_cover_r2");
   end
endmodule

// File: rtl/alu4f_addsub.sv
module alu4f_addsub #(
   parameter int WIDTH      = 32,
   parameter bit RIPPLE_ADD = 1'b1
) (
   input  logic [WIDTH-1:0] lhs,
   input  logic [WIDTH-1:0] rhs,
   input  logic             do_sub,
   output logic [WIDTH-1:0] sum_out,
   output logic             carry_out,
   output logic             ovf_out
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] rhs_eff;
   assign rhs_eff = rhs ^ {WIDTH{do_sub}};

   generate
      if (RIPPLE_ADD) begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = do_sub;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum_out[i]  = lhs[i] ^ rhs_eff[i] ^ chain[i];
            assign chain[i+1]  = (lhs[i] & rhs_eff[i]) |
                                 (chain[i] & (lhs[i] ^ rhs_eff[i]));
         end
         assign carry_out = chain[WIDTH];
      end else begin : g_behav
         logic [WIDTH:0] wide_sum;
         assign wide_sum  = {1'b0, lhs} + {1'b0, rhs_eff} + {{WIDTH{1'b0}}, do_sub};
         assign sum_out   = wide_sum[MSB:0];
         assign carry_out = wide_sum[WIDTH];
      end
   endgenerate

   assign ovf_out = (lhs[MSB] ~^ rhs_eff[MSB]) & (sum_out[MSB] ^ lhs[MSB]);

   always_comb begin
      // sum matches modular addition (R3)
      p_add_value_r3: assert (do_sub || sum_out == lhs + rhs)
         else $error("p_add_value_r3");
      // difference matches modular subtraction (R4)
      p_sub_value_r4: assert (!do_sub || sum_out == lhs - rhs)
         else $error("p_sub_value_r4");
      // carry on subtraction means no borrow (R5)
      p_sub_carry_r5: assert (!do_sub || carry_out == (lhs >= rhs))
         else $error("p_sub_carry_r5");
      // overflow only when the operands agree in sign (R6)
      p_no_overflow_r6: assert (!ovf_out || (lhs[MSB] == (rhs[MSB] ^ do_sub)))
         else $error("p_no_overflow_r6");
   end
endmodule

// File: rtl/alu4f_top.sv
module alu4f_top #(
   parameter int WIDTH      = 32,
   parameter bit RIPPLE_ADD = 1'b1
) (
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic [1:0]       op_sel,
   output logic [WIDTH-1:0] result,
   output logic             flag_zero,
   output logic             flag_neg,
   output logic             flag_carry,
   output logic             flag_ovf
);
   import alu4f_pkg::*;

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu4f_top: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] logic_res;
   logic [WIDTH-1:0] arith_res;
   logic             inner_sel;
   logic             pair_sel;

   assign inner_sel = op_sel[SEL_INNER];
   assign pair_sel  = op_sel[SEL_PAIR];

   alu4f_logic #(.WIDTH(WIDTH)) u_logic (
      .lhs      (opnd_a),
      .rhs      (opnd_b),
      .pick_or  (inner_sel),
      .bits_out (logic_res)
   );

   alu4f_addsub #(.WIDTH(WIDTH), .RIPPLE_ADD(RIPPLE_ADD)) u_addsub (
      .lhs       (opnd_a),
      .rhs       (opnd_b),
      .do_sub    (inner_sel),
      .sum_out   (arith_res),
      .carry_out (flag_carry),
      .ovf_out   (flag_ovf)
   );

   assign result    = pair_sel ? arith_res : logic_res;
   assign flag_zero = ~|result;
   assign flag_neg  = result[MSB];

   always_comb begin
      // a zero result is never negative (R7, R8)
      p_zero_not_neg_r8: assert (!(flag_zero && flag_neg))
         else $error("p_zero_not_neg_r8");
      // arithmetic codes route the adder sum (R3, R4)
      p_arith_route_r3: assert (!pair_sel || result == arith_res)
         else $error("p_arith_route_r3");
      // zero after subtraction implies equal operands and a carry (R5)
      p_sub_zero_carry_r5: assert (!(op_sel == OP_SUB && flag_zero) || flag_carry)
         else $error("p_sub_zero_carry_r5");
   end
endmodule

// File: tb/alu4f_top_bench.sv
module alu4f_top_bench;
   import alu4f_pkg::*;

   localparam int  W          = 32;
   localparam time CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic [W-1:0] a, b;
   logic [1:0]   op;
   logic [W-1:0] res;
   logic         z, n, c, v;
   int           n_tests = 0;
   int           n_fail  = 0;
   bit           done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu4f_top #(.WIDTH(W)) u_alu4f_top (
      .opnd_a(a), .opnd_b(b), .op_sel(op), .result(res),
      .flag_zero(z), .flag_neg(n), .flag_carry(c), .flag_ovf(v)
   );

   task automatic chk(input string req, input string what,
                      input logic [W-1:0] got, input logic [W-1:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s a=%h b=%h op=%b actual=%h expected=%h",
                  req, what, a, b, op, got, exp);
      end
   endtask

   // drive at posedge, compare at the following negedge
   task automatic run(input logic [W-1:0] ia, input logic [W-1:0] ib, input logic [1:0] iop);
      longint sa, sb, sr;
      logic [W:0] ucarry;
      logic [W-1:0] er;
      logic ec, ev;
      @(posedge clk);
      a = ia; b = ib; op = iop;
      @(negedge clk);
      sa = longint'($signed(ia));
      sb = longint'($signed(ib));
      // adder flags follow the low code bit (R9)
      if (iop[0]) begin
         sr = sa - sb;
         ec = (ia >= ib);
      end else begin
         sr = sa + sb;
         ucarry = {1'b0, ia} + {1'b0, ib};
         ec = ucarry[W];
      end
      ev = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      case (iop)
         2'b00: er = ia & ib;
         2'b01: er = ia | ib;
         2'b10: er = ia + ib;
         default: er = ia - ib;
      endcase
      case (iop)
         2'b00: chk("R1", "result", res, er);
         2'b01: chk("R2", "result", res, er);
         2'b10: chk("R3", "result", res, er);
         default: chk("R4", "result", res, er);
      endcase
      chk(iop[1] ? "R5" : "R9", "carry", {{(W-1){1'b0}}, c}, {{(W-1){1'b0}}, ec});
      chk(iop[1] ? "R6" : "R9", "ovf",   {{(W-1){1'b0}}, v}, {{(W-1){1'b0}}, ev});
      chk("R7", "neg",  {{(W-1){1'b0}}, n}, {{(W-1){1'b0}}, er[W-1]});
      chk("R8", "zero", {{(W-1){1'b0}}, z}, {{(W-1){1'b0}}, (er == '0)});
   endtask

   task automatic t_logic_ops();   // R1 R2 R9
      run(32'hF0F0_1234, 32'h0FF0_FF00, OP_AND);
      run(32'hF0F0_1234, 32'h0FF0_FF00, OP_OR);
      run(32'h5555_5555, 32'hAAAA_AAAA, OP_AND);   // zero result
      run(32'h0000_0000, 32'h0000_0000, OP_OR);
      run(32'h8000_0000, 32'h8000_0000, OP_AND);   // add flags: carry and overflow
      run(32'h7FFF_FFFF, 32'hFFFF_FFFF, OP_OR);    // sub flags: overflow
   endtask

   task automatic t_add_edges();   // R3 R5 R6
      run(32'h7FFF_FFFF, 32'h0000_0001, OP_ADD);   // signed overflow, no carry
      run(32'hFFFF_FFFF, 32'h0000_0001, OP_ADD);   // carry, zero result
      run(32'h8000_0000, 32'h8000_0000, OP_ADD);   // carry and overflow
      run(32'h0000_0003, 32'h0000_0004, OP_ADD);
   endtask

   task automatic t_sub_edges();   // R4 R5 R6 R8
      run(32'h8000_0000, 32'h0000_0001, OP_SUB);   // signed overflow
      run(32'h1234_5678, 32'h1234_5678, OP_SUB);   // A-A zero, carry set
      run(32'h0000_0001, 32'h0000_0002, OP_SUB);   // borrow, negative
      run(32'h0000_0000, 32'h8000_0000, OP_SUB);   // overflow from inverted B sign
      run(32'hFFFF_FFFF, 32'h0000_0000, OP_SUB);
   endtask

   task automatic t_random();      // all codes
      for (int k = 0; k < 400; k++) begin
         run($urandom, $urandom, 2'(k % 4));
      end
   endtask

   initial begin
      a = '0; b = '0; op = OP_AND;
      @(negedge clk);
      chk("R8", "zero_at_start", {{(W-1){1'b0}}, z}, {{(W-1){1'b0}}, 1'b1});
      t_logic_ops();
      t_add_edges();
      t_sub_edges();
      t_random();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule